// File: doc/BRIEF.md
# UART Address and Character Match Detector

This block sits behind a UART receiver and looks at each character the receiver delivers. It works in one of two ways. While the receiver is awake, it compares every character in full against an 8-bit match register. A hit raises a sticky flag, which can mark things such as an end-of-block character. While the receiver is muted, it ignores plain data and looks only at address characters, which are characters whose top bit is 1. An address character that carries this node's address ends the mute and produces a one-cycle wake pulse.

Address matching uses either the low 4 bits or the low 7 bits of the character, set by a mode input. The match register can be loaded only while reception is off or the whole UART is off, so software cannot change it under a live receiver. A character is seen only when both the UART enable and the receiver enable are high.

Top module: `uart_addr_match`

## Requirements
- R1: After reset, `node_addr` is 0x00, and `char_match`, `wake` and `muted` are all 0.
- R2: A pulse on `addr_wr` loads `addr_wdata` into `node_addr` at the next edge, but only while `rx_en` or `uart_en` is 0. While both are 1, the write is ignored and `node_addr` keeps its value.
- R3: While not muted, a character strobe whose `rx_data` equals `node_addr` in all 8 bits sets `char_match` at the next edge. Any other character leaves `char_match` as it was.
- R4: `char_match` stays at 1 until `match_clr` is pulsed, and then clears at the next edge. If a set and a clear happen in the same cycle, the set wins.
- R5: While muted and `addr_7bit`=1, a character with bit 7 = 1 whose bits [6:0] equal `node_addr[6:0]` drives `wake` high for exactly one cycle after the strobe edge and clears `muted` at that same edge.
- R6: While muted and `addr_7bit`=0, a character with bit 7 = 1 whose bits [3:0] equal `node_addr[3:0]` wakes the block as in R5. Bits [6:4] of the character and of `node_addr` play no part.
- R7: While muted, characters with bit 7 = 0 and address characters that do not match produce no `wake`, leave `muted` at 1, and never set `char_match`.
- R8: A pulse on `mute_req` sets `muted` at the next edge. If an address match happens in the same cycle, the match wins and `muted` ends up 0.
- R9: A character strobe while `uart_en`=0 or `rx_en`=0 has no effect on `char_match`, `wake` or `muted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_en | input | 1 | Whole-UART enable |
| rx_en | input | 1 | Receiver enable |
| addr_wr | input | 1 | Write strobe for the match register |
| addr_wdata | input | 8 | Value to write into the match register |
| addr_7bit | input | 1 | 1 selects 7-bit address matching, 0 selects 4-bit |
| mute_req | input | 1 | Strobe that puts the receiver into mute |
| match_clr | input | 1 | Strobe that clears the character-match flag |
| rx_valid | input | 1 | One-cycle strobe marking a received character |
| rx_data | input | 8 | Received character |
| node_addr | output | 8 | Current match register value |
| char_match | output | 1 | Sticky character-match flag |
| wake | output | 1 | One-cycle pulse on an address-match wakeup |
| muted | output | 1 | Mute state; a fall marks the exit from mute |

## Verification
The hardest case to reach is a wakeup in 4-bit mode where only the low nibble matches. Random characters seldom carry bit 7 set and a matching nibble while the block happens to be muted. The random stimulus therefore builds many characters from the current match value: it forces bit 7 high and scrambles the upper bits, and it asks for mute often, so matches that differ only above bit 3 occur many times. Directed sequences then set up the same-cycle conflicts: a set against a clear, a mute request against a wakeup, and a write while the receiver is enabled.

// File: rtl/uart_addr_match.sv
module uart_addr_match #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uart_en,
  input  logic          rx_en,
  input  logic          addr_wr,
  input  logic [CW-1:0] addr_wdata,
  input  logic          addr_7bit,
  input  logic          mute_req,
  input  logic          match_clr,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic [CW-1:0] node_addr,
  output logic          char_match,
  output logic          wake,
  output logic          muted
);
  localparam int NIB = 4;
  localparam int AW  = CW - 1;

  logic active, take, is_addr, hit_wide, hit_nib, addr_hit, full_hit;

  assign active   = uart_en & rx_en;
  assign take     = rx_valid & active;
  assign is_addr  = rx_data[CW-1];
  assign hit_wide = rx_data[AW-1:0] == node_addr[AW-1:0];
  assign hit_nib  = rx_data[NIB-1:0] == node_addr[NIB-1:0];
  assign addr_hit = take & muted & is_addr & (addr_7bit ? hit_wide : hit_nib);
  assign full_hit = take & ~muted & (rx_data == node_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_addr  <= '0;
      char_match <= 1'b0;
      wake       <= 1'b0;
      muted      <= 1'b0;
    end else begin
      if (addr_wr && !active) node_addr <= addr_wdata;
      char_match <= full_hit | (char_match & ~match_clr);
      wake       <= addr_hit;
      if (addr_hit)      muted <= 1'b0;
      else if (mute_req) muted <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_addr_match_chk.sv
module uart_addr_match_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uart_en,
  input logic          rx_en,
  input logic          match_clr,
  input logic          rx_valid,
  input logic [CW-1:0] rx_data,
  input logic [CW-1:0] node_addr,
  input logic          char_match,
  input logic          wake,
  input logic          muted
);
  a_r2_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && rx_en) |=> $stable(node_addr));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (char_match && !match_clr) |=> char_match);

  a_r5_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  a_r5_wake_unmutes: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !muted);

  a_r7_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && rx_valid && !rx_data[CW-1]) |=> (!wake && muted));

  a_r9_idle_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!(uart_en && rx_en)) |=> !wake);
endmodule

bind uart_addr_match uart_addr_match_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .rx_en(rx_en),
  .match_clr(match_clr), .rx_valid(rx_valid), .rx_data(rx_data),
  .node_addr(node_addr), .char_match(char_match), .wake(wake), .muted(muted)
);

// File: tb/uart_addr_match_bench.sv
module uart_addr_match_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_en = 0, rx_en = 0, addr_wr = 0, addr_7bit = 0;
  logic mute_req = 0, match_clr = 0, rx_valid = 0;
  logic [7:0] addr_wdata = 0, rx_data = 0;
  logic [7:0] node_addr;
  logic char_match, wake, muted;

  int checks = 0, errors = 0;
  logic [7:0] m_addr = 0;
  logic m_flag = 0, m_wake = 0, m_mute = 0;

  always #4 clk = ~clk;

  uart_addr_match u_uart_addr_match (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .rx_en(rx_en),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .addr_7bit(addr_7bit),
    .mute_req(mute_req), .match_clr(match_clr), .rx_valid(rx_valid),
    .rx_data(rx_data), .node_addr(node_addr), .char_match(char_match),
    .wake(wake), .muted(muted)
  );

  function automatic logic addr_ok(logic [7:0] d, logic [7:0] a, logic m7);
    if (!d[7]) return 1'b0;
    return m7 ? (d[6:0] == a[6:0]) : (d[3:0] == a[3:0]);
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    logic act, hit, full;
    act  = uart_en & rx_en;
    hit  = rx_valid & act & m_mute & addr_ok(rx_data, m_addr, addr_7bit);
    full = rx_valid & act & ~m_mute & (rx_data == m_addr);
    if (!rst_n) begin
      m_addr = 0; m_flag = 0; m_wake = 0; m_mute = 0;
    end else begin
      if (addr_wr && !act) m_addr = addr_wdata;
      m_flag = full | (m_flag & ~match_clr);
      m_wake = hit;
      if (hit) m_mute = 0; else if (mute_req) m_mute = 1;
    end
    @(negedge clk);
    chk("R2 node_addr", node_addr, m_addr);
    chk("R3/R4 char_match", {7'b0, char_match}, {7'b0, m_flag});
    chk("R5/R6 wake", {7'b0, wake}, {7'b0, m_wake});
    chk("R7/R8 muted", {7'b0, muted}, {7'b0, m_mute});
  endtask

  task automatic idle();
    addr_wr = 0; mute_req = 0; match_clr = 0; rx_valid = 0;
  endtask

  task automatic write_addr(logic [7:0] v);
    rx_en = 0; addr_wr = 1; addr_wdata = v; step(); idle(); rx_en = 1;
  endtask

  task automatic send(logic [7:0] d);
    rx_valid = 1; rx_data = d; step(); idle();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    @(negedge clk);
    step(); step();
    rst_n = 1;
    chk("R1 node_addr", node_addr, 8'h00);
    chk("R1 flags", {5'b0, char_match, wake, muted}, 8'h00);
    uart_en = 1; rx_en = 1;

    // R2: write while receiving is dropped, while rx off it lands
    addr_wr = 1; addr_wdata = 8'hA5; step(); idle();
    chk("R2 locked write", node_addr, 8'h00);
    write_addr(8'hC3);
    chk("R2 open write", node_addr, 8'hC3);
    uart_en = 0; rx_en = 1; addr_wr = 1; addr_wdata = 8'h5A; step(); idle(); uart_en = 1;
    chk("R2 uart off write", node_addr, 8'h5A);

    // R3/R4 full compare and sticky flag
    send(8'h5B);
    chk("R3 miss", {7'b0, char_match}, 8'h0);
    send(8'h5A);
    chk("R3 hit", {7'b0, char_match}, 8'h1);
    step();
    chk("R4 sticky", {7'b0, char_match}, 8'h1);
    match_clr = 1; rx_valid = 1; rx_data = 8'h5A; step(); idle();
    chk("R4 set wins", {7'b0, char_match}, 8'h1);
    match_clr = 1; step(); idle();
    chk("R4 cleared", {7'b0, char_match}, 8'h0);

    // R9 disabled receiver ignores characters
    rx_en = 0; send(8'h5A); rx_en = 1;
    chk("R9 no flag", {7'b0, char_match}, 8'h0);

    // R6 4-bit wake with differing upper bits
    write_addr(8'h35); addr_7bit = 0;
    mute_req = 1; step(); idle();
    chk("R8 muted", {7'b0, muted}, 8'h1);
    send(8'h15);
    chk("R7 data ignored", {6'b0, wake, muted}, 8'h1);
    send(8'hF4);
    chk("R7 wrong addr", {6'b0, wake, muted}, 8'h1);
    send(8'h35);
    chk("R7 no char_match", {7'b0, char_match}, 8'h0);
    send(8'hF5);
    chk("R6 wake", {6'b0, wake, muted}, 8'h2);
    step();
    chk("R5 pulse ends", {7'b0, wake}, 8'h0);

    // R5 7-bit mode: nibble-only match must not wake
    addr_7bit = 1; mute_req = 1; step(); idle();
    send(8'hC5);
    chk("R5 nibble only", {6'b0, wake, muted}, 8'h1);
    mute_req = 1; rx_valid = 1; rx_data = 8'hB5; step(); idle();
    chk("R8 wake beats mute", {6'b0, wake, muted}, 8'h2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      uart_en   = ($urandom_range(0, 19) != 0);
      rx_en     = ($urandom_range(0, 9) != 0);
      addr_7bit = $urandom_range(0, 1);
      addr_wr   = ($urandom_range(0, 15) == 0);
      addr_wdata = $urandom;
      mute_req  = ($urandom_range(0, 5) == 0);
      match_clr = ($urandom_range(0, 7) == 0);
      rx_valid  = ($urandom_range(0, 2) != 0);
      if (r < 30)      rx_data = m_addr;
      else if (r < 60) rx_data = {1'b1, 3'($urandom), m_addr[3:0]};
      else if (r < 75) rx_data = {1'b1, m_addr[6:0]};
      else             rx_data = $urandom;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule